// File: doc/BRIEF.md
# SPI Frame Length and Parity Checker

This block is the receive front end of a SPI target. It watches chip select (active low), the serial clock and the serial data input, and brings all three into the system clock domain through synchronizer chains. While chip select is low, each rising edge of the synchronized serial clock shifts one data bit into a word register, most significant bit first. The same edge increments a bit counter and toggles a running parity bit.

When chip select returns high, the block issues a verdict on the frame. A frame is accepted only when exactly `WORD_W` bits (32 by default) were clocked in and the total number of ones, parity bit included, is odd. An accepted frame produces a one-cycle valid strobe, and the received word is placed on the output. A frame of the wrong length produces a one-cycle framing-error pulse. A frame of the right length with even parity produces a one-cycle parity-error pulse. A rejected word is discarded, and the output word keeps the last accepted value. A chip-select window in which no clock edge arrived produces no pulse at all.

Command decoding, response shifting and register access belong to the blocks that consume the valid strobe.

Top module: `spi_frame_checker`

## Requirements
- R1: After reset, `word_valid_o`, `frame_err_o` and `parity_err_o` are 0 and `word_o` is all zeros.
- R2: A frame with exactly 32 rising serial-clock edges and an odd number of ones produces a single `word_valid_o` pulse. On that pulse, `word_o` holds the bits, with the first bit received at bit 31 and the last at bit 0.
- R3: A frame with at least 1 but fewer than 32 clock edges produces a single `frame_err_o` pulse and no valid pulse.
- R4: A frame with more than 32 clock edges produces a single `frame_err_o` pulse. This holds even when the count would wrap back to 32 (for example 96 edges), because the bit counter saturates at 33.
- R5: A chip-select low window with no clock edges produces no result pulse. Clock edges while chip select is high are ignored and produce no pulse.
- R6: A 32-bit frame with an even number of ones produces a single `parity_err_o` pulse and no valid pulse.
- R7: The length check takes priority: a frame of the wrong length with even parity raises only `frame_err_o`.
- R8: Each of the three result outputs is high for one system-clock cycle per frame, and at most one of them is high in any cycle.
- R9: The falling edge of chip select clears the bit counter and parity, so a frame after an aborted frame is judged on its own bits.
- R10: `word_o` changes only together with a `word_valid_o` pulse. After a rejected frame it still holds the last accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the SPI bus, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the SPI bus, asynchronous |
| si_i | input | 1 | Serial data input, sampled on rising serial clock |
| word_valid_o | output | 1 | One-cycle strobe: accepted frame |
| word_o | output | WORD_W | Last accepted word, MSB received first |
| frame_err_o | output | 1 | One-cycle pulse: bit count was not WORD_W |
| parity_err_o | output | 1 | One-cycle pulse: correct length, even number of ones |

## Verification
The checker watches every cycle for the following properties:
- The three result signals stay mutually exclusive, and each lasts a single cycle.
- Results appear only while synchronized chip select is high.
- The output word moves only with a valid strobe, and an accepted word always has odd parity.
- The bit counter never passes its saturation value and is cleared right after chip select falls.

Which verdict a given frame earns can only be shown by the bench's frames: short, long, wrapping-length, empty and even-parity frames. The same goes for the bit order in the word and for the word being kept after rejected frames.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic [1:0] {
      SFC_NONE = 2'd0,
      SFC_OK   = 2'd1,
      SFC_LEN  = 2'd2,
      SFC_PAR  = 2'd3
   } sfc_verdict_e;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfc_front.sv
module sfc_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sclk_i,
   input  logic si_i,
   output logic cs_hi,
   output logic cs_fall,
   output logic cs_rise,
   output logic bit_stb,
   output logic bit_val
);
   logic [2:0] raw_in, syn_out;
   logic       cs_s, sclk_s, si_s;
   logic       cs_q, sclk_q;

   assign raw_in = {cs_n_i, sclk_i, si_i};

   sfc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (syn_out)
   );

   assign {cs_s, sclk_s, si_s} = syn_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_s;
         sclk_q <= sclk_s;
      end
   end

   assign cs_hi   = cs_s;
   assign cs_fall = cs_q & ~cs_s;
   assign cs_rise = ~cs_q & cs_s;
   assign bit_stb = ~cs_s & sclk_s & ~sclk_q;
   assign bit_val = si_s;
endmodule

// File: rtl/sfc_accum.sv
module sfc_accum #(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              stb,
   input  logic              bit_i,
   output logic [WORD_W-1:0] shreg_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              par_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_o <= '0;
         cnt_o   <= '0;
         par_o   <= 1'b0;
      end else if (clr) begin
         cnt_o   <= '0;
         par_o   <= 1'b0;
      end else if (stb) begin
         shreg_o <= {shreg_o[WORD_W-2:0], bit_i};
         par_o   <= par_o ^ bit_i;
         if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/sfc_judge.sv
module sfc_judge
   import sfc_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int CNT_W      = 6,
   parameter bit PARITY_ODD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              par,
   input  logic [WORD_W-1:0] shreg,
   output logic              valid_o,
   output logic              ferr_o,
   output logic              perr_o,
   output logic [WORD_W-1:0] word_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   logic         par_ok;
   sfc_verdict_e verdict;

   generate
      if (PARITY_ODD) begin : g_odd
         assign par_ok = par;
      end else begin : g_even
         assign par_ok = ~par;
      end
   endgenerate

   always_comb begin
      verdict = SFC_NONE;
      if (done && cnt != '0) begin
         if (cnt != CNT_FULL)  verdict = SFC_LEN;
         else if (!par_ok)     verdict = SFC_PAR;
         else                  verdict = SFC_OK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
         perr_o  <= 1'b0;
         word_o  <= '0;
      end else begin
         valid_o <= (verdict == SFC_OK);
         ferr_o  <= (verdict == SFC_LEN);
         perr_o  <= (verdict == SFC_PAR);
         if (verdict == SFC_OK) word_o <= shreg;
      end
   end
endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker #(
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit PARITY_ODD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              si_i,
   output logic              word_valid_o,
   output logic [WORD_W-1:0] word_o,
   output logic              frame_err_o,
   output logic              parity_err_o
);
   localparam int CNT_W = $clog2(WORD_W + 2);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("spi_frame_checker: WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("spi_frame_checker: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             cs_hi, cs_fall, cs_rise, bit_stb, bit_val;
   logic [CNT_W-1:0] bit_cnt;
   logic             par_acc;
   logic [WORD_W-1:0] shreg;

   sfc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n_i (cs_n_i),
      .sclk_i (sclk_i),
      .si_i   (si_i),
      .cs_hi  (cs_hi),
      .cs_fall(cs_fall),
      .cs_rise(cs_rise),
      .bit_stb(bit_stb),
      .bit_val(bit_val)
   );

   sfc_accum #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cs_fall),
      .stb    (bit_stb),
      .bit_i  (bit_val),
      .shreg_o(shreg),
      .cnt_o  (bit_cnt),
      .par_o  (par_acc)
   );

   sfc_judge #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PARITY_ODD(PARITY_ODD)) u_judge (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (cs_rise),
      .cnt    (bit_cnt),
      .par    (par_acc),
      .shreg  (shreg),
      .valid_o(word_valid_o),
      .ferr_o (frame_err_o),
      .perr_o (parity_err_o),
      .word_o (word_o)
   );
endmodule

// File: rtl/spi_frame_checker_chk.sv
module spi_frame_checker_chk #(
   parameter int WORD_W     = 32,
   parameter int CNT_W      = 6,
   parameter bit PARITY_ODD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_hi,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              word_valid_o,
   input logic [WORD_W-1:0] word_o,
   input logic              frame_err_o,
   input logic              parity_err_o
);
   p_onehot_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({word_valid_o, frame_err_o, parity_err_o}));

   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o);

   p_ferr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o);

   p_perr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err_o |=> !parity_err_o);

   p_result_cs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o || frame_err_o || parity_err_o) |-> cs_hi);

   p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid_o |-> $stable(word_o));

   p_valid_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> (($countones(word_o) & 1) == int'(PARITY_ODD)));

   p_cnt_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bit_cnt) <= WORD_W + 1);

   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_hi) |=> (bit_cnt == '0));
endmodule

bind spi_frame_checker spi_frame_checker_chk #(
   .WORD_W(WORD_W), .CNT_W(CNT_W), .PARITY_ODD(PARITY_ODD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_hi       (cs_hi),
   .bit_cnt     (bit_cnt),
   .word_valid_o(word_valid_o),
   .word_o      (word_o),
   .frame_err_o (frame_err_o),
   .parity_err_o(parity_err_o)
);

// File: tb/spi_frame_checker_tb_top.sv
module spi_frame_checker_tb_top;
   localparam int W = 32;

   // Expected-result codes: 0 none, 1 valid, 2 framing error, 3 parity error
   typedef struct packed {
      int unsigned  nbits;
      logic [127:0] bits;
      logic [1:0]   exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{32, 128'h0000_0001, 2'd1},   // R2 single one
      '{32, 128'hA5A5_0F0E, 2'd1},   // R2 mixed, 15 ones
      '{32, 128'hFFFF_FFFF, 2'd3},   // R6 32 ones
      '{32, 128'h0,         2'd3},   // R6 zero ones
      '{31, 128'h1,         2'd2},   // R3 short by one
      '{33, 128'h1,         2'd2},   // R4 long by one
      '{1,  128'h1,         2'd2},   // R3 single bit, R9 next frame fresh
      '{32, 128'h1234_5678, 2'd1},   // R9 accepted after aborted frame
      '{0,  128'h0,         2'd0},   // R5 no clocks
      '{96, 128'h8000_0000, 2'd2},   // R4 96 edges, wrap would give 32
      '{8,  128'h03,        2'd2}    // R7 short with even parity
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
   logic         word_valid, frame_err, parity_err;
   logic [W-1:0] word;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] last_word = '0;
   int nv, nf, np;

   always #5 clk = ~clk;

   spi_frame_checker dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n),
      .sclk_i      (sclk),
      .si_i        (si),
      .word_valid_o(word_valid),
      .word_o      (word),
      .frame_err_o (frame_err),
      .parity_err_o(parity_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic observe(input int ncyc);
      nv = 0; nf = 0; np = 0;
      repeat (ncyc) begin
         @(negedge clk);
         nv += int'(word_valid);
         nf += int'(frame_err);
         np += int'(parity_err);
      end
   endtask

   task automatic send(input int unsigned nbits, input logic [127:0] bits);
      cs_n = 1'b0;
      wait_clk(6);
      for (int i = int'(nbits) - 1; i >= 0; i--) begin
         si = bits[i];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(4);
      cs_n = 1'b1;
      observe(12);
      wait_clk(6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(4);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!word_valid, "R1", "valid after reset", W'(word_valid), '0);
      check(!frame_err,  "R1", "frame_err after reset", W'(frame_err), '0);
      check(!parity_err, "R1", "parity_err after reset", W'(parity_err), '0);
      check(word == '0,  "R1", "word after reset", word, '0);

      // Vector table
      for (int k = 0; k < NV; k++) begin
         int ev, ef, ep;
         logic [W-1:0] ew;
         send(VECS[k].nbits, VECS[k].bits);
         ev = (VECS[k].exp == 2'd1) ? 1 : 0;
         ef = (VECS[k].exp == 2'd2) ? 1 : 0;
         ep = (VECS[k].exp == 2'd3) ? 1 : 0;
         ew = (VECS[k].exp == 2'd1) ? VECS[k].bits[W-1:0] : last_word;
         // R8 pulse counts encode which result and its single-cycle width
         check(nv == ev && nf == ef && np == ep, "R8", $sformatf("vector %0d pulses v/f/p", k),
               W'({nv[7:0], nf[7:0], np[7:0]}), W'({ev[7:0], ef[7:0], ep[7:0]}));
         // R2 word content, R10 word kept after rejection
         check(word == ew, (VECS[k].exp == 2'd1) ? "R2" : "R10",
               $sformatf("vector %0d word", k), word, ew);
         last_word = ew;
      end

      // R5 clocks while chip select is high are ignored
      for (int i = 0; i < 40; i++) begin
         si = i[0];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      observe(12);
      check(nv + nf + np == 0, "R5", "pulses with cs high", W'(nv + nf + np), '0);
      check(word == last_word, "R5", "word with cs high", word, last_word);

      // R9 reset mid-frame, then a clean frame is accepted
      cs_n = 1'b0;
      wait_clk(6);
      for (int i = 0; i < 10; i++) begin
         si = 1'b1; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
      end
      cs_n = 1'b1;
      observe(12);
      check(nf == 1 && nv == 0, "R3", "aborted 10-bit frame", W'(nf), W'(1));
      send(32, 128'h8000_0000);
      check(nv == 1 && word == 32'h8000_0000, "R9", "frame after abort", word, 32'h8000_0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule